// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

The controller watches a wide vector of GPIO inputs, split into groups of sixteen lines, and turns selected level or edge conditions on those lines into interrupt requests for a processor. Every input is first synchronised into the local clock. Each line then sets a sticky pending bit when its trigger condition is met. A per-line mask decides whether a pending line reaches the single combined interrupt output. Four adjacent lines share one trigger selector, so one 16-bit configuration half-word covers a whole group.

Software reaches the configuration, mask and pending state through a small word-addressed register port. Two groups share each 32-bit register: the even group sits in the low half and the odd group in the high half. A read-only service word names one pending, unmasked line by group and pin, so an interrupt handler can loop on it until it reads zero. In that word, group 2 covers two 8-pin banks, pins 0 to 7 and pins 8 to 15; the hardware reports the pin number unchanged and leaves the split to software.

Top module: `grp_eint_ctrl`

## Requirements
- R1: After reset every trigger field is 0, every mask bit is 1 and every pending bit is 0. `rdata_o` is 0, the service word reads 0 and `irq_o` is 0. The synchroniser stages reset to 1.
- R2: A 4-bit trigger code sets a line's pending bit as follows: 0 while the synchronised input is low, 1 while it is high, 2 on a falling edge, 4 on a rising edge and 6 on either edge. Any other code never sets the pending bit.
- R3: Configuration register k is at word address k. Its bits 15:0 serve group 2k and its bits 31:16 serve group 2k+1. Within the register, line i (0 to 31) takes its trigger from the field at bits 4*(i/4)+3 : 4*(i/4). Mask register k is at word 8+k and pending register k at word 16+k, with the same bit layout.
- R4: A mask bit of 1 keeps its line out of `irq_o` and out of the service word, but the pending bit still records the event. A mask bit of 0 lets the line through.
- R5: Writing a pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: In level modes (codes 0 and 1) the pending bit is set again in the same cycle as a clear while the input stays at its active level, so a clear has no lasting effect until the level goes away.
- R7: The service word at address 24 reads group index + 1 in bits 7:4 and the pin in bits 3:0, with zeros above. It reads 0 when no unmasked line is pending. When several lines qualify, the lowest group wins, then the lowest pin within that group.
- R8: An input change reaches the pending bit and `irq_o` on the third rising clock edge after it is applied: two synchroniser flops, then the pending register.
- R9: `irq_o` is high exactly when some line is both pending and unmasked.
- R10: Writes to the service address are ignored. Reads of addresses that map to no register, and of configuration registers beyond the last group pair, return 0.
- R11: When NUM_GROUPS is odd, the high half of the last register pair does not exist: it reads 0 in the configuration, mask and pending registers.
- R12: A read (req_i high, we_i low) samples the addressed register on the clock edge, and rdata_o holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpio_i | input | NUM_GROUPS*16 | Raw GPIO inputs, line 16*g+p is pin p of group g |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the controller with the default nine groups. This gives an odd group count, so the missing high half of the fifth register pair can be checked, and the last real group (index 8) can be made to compete with group 1 in the service priority. A table walks every valid trigger code, and several invalid ones, through a before/after input pair on one line. Directed tests then cover shared trigger fields across the register halves, masking, clear-on-one, level re-arming, the exact three-edge latency and the read-only or unmapped addresses.

// File: rtl/grp_eint_pkg.sv
package grp_eint_pkg;
  localparam int LINES   = 16;
  localparam int FIELD_W = 4;
  localparam int ADDR_W  = 5;
  localparam int MAX_REGS = 8;

  localparam int CFG_BASE  = 0;
  localparam int MASK_BASE = 8;
  localparam int PEND_BASE = 16;
  localparam int SVC_ADDR  = 24;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eint_group.sv
module eint_group
  import grp_eint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] cfg_i,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] prev_q, pend_q, hit, bad_lines;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  // one selector per four adjacent lines
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      case (cfg_i[FIELD_W*(i/4) +: FIELD_W])
        TRIG_LOW:  hit[i] = ~lvl_i[i];
        TRIG_HIGH: hit[i] = lvl_i[i];
        TRIG_FALL: hit[i] = prev_q[i] & ~lvl_i[i];
        TRIG_RISE: hit[i] = ~prev_q[i] & lvl_i[i];
        TRIG_BOTH: hit[i] = prev_q[i] ^ lvl_i[i];
        default:   hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | hit;
  end

  assign pend_o = pend_q;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      logic [FIELD_W-1:0] c;
      c = cfg_i[FIELD_W*(i/4) +: FIELD_W];
      bad_lines[i] = !(c == 4'd0 || c == 4'd1 || c == 4'd2 || c == 4'd4 || c == 4'd6);
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~clr_i) != '0) |=> (((($past(pend_q) & ~$past(clr_i))) & ~pend_q) == '0))
    else $error("pending bit lost without clear"); // R5

  AST_BAD_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_lines != '0) |=> ((pend_q & ~$past(pend_q) & $past(bad_lines)) == '0))
    else $error("pending set under unused trigger code"); // R2
endmodule

// File: rtl/eint_arbiter.sv
module eint_arbiter
  import grp_eint_pkg::*;
#(
  parameter int NUM_GROUPS = 9
) (
  input  logic [NUM_GROUPS*LINES-1:0] pend_i,
  input  logic [NUM_GROUPS*LINES-1:0] mask_i,
  output logic [3:0]                  grp_o,
  output logic [3:0]                  pin_o
);
  // descending scan: last hit is lowest group, lowest pin
  always_comb begin
    grp_o = '0;
    pin_o = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      for (int p = LINES - 1; p >= 0; p--) begin
        if (pend_i[g*LINES+p] && !mask_i[g*LINES+p]) begin
          grp_o = 4'(g + 1);
          pin_o = 4'(p);
        end
      end
    end
  end
endmodule

// File: rtl/grp_eint_ctrl.sv
module grp_eint_ctrl
  import grp_eint_pkg::*;
#(
  parameter int NUM_GROUPS = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_GROUPS*LINES-1:0] gpio_i,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic                        irq_o
);
  localparam int NUM_LINES = NUM_GROUPS * LINES;
  localparam int NUM_REGS  = (NUM_GROUPS + 1) / 2;
  localparam int PAD_G     = 2 * MAX_REGS;

  logic [NUM_LINES-1:0] lvl, pend_flat, mask_flat;
  logic [LINES-1:0] cfg_q  [NUM_GROUPS];
  logic [LINES-1:0] mask_q [NUM_GROUPS];
  logic [LINES-1:0] cfg_pad  [PAD_G];
  logic [LINES-1:0] mask_pad [PAD_G];
  logic [LINES-1:0] pend_pad [PAD_G];
  logic [3:0]  svc_grp, svc_pin;
  logic [31:0] rd_word, rdata_q;
  logic        wr;

  assign wr = req_i & we_i;

  eint_sync #(.W(NUM_LINES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (lvl)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int K = g / 2;
    localparam int H = g % 2;
    logic [LINES-1:0] clr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g]  <= '0;
        mask_q[g] <= '1;
      end else if (wr) begin
        if (addr_i == ADDR_W'(CFG_BASE + K))  cfg_q[g]  <= wdata_i[LINES*H +: LINES];
        if (addr_i == ADDR_W'(MASK_BASE + K)) mask_q[g] <= wdata_i[LINES*H +: LINES];
      end
    end

    assign clr = (wr && addr_i == ADDR_W'(PEND_BASE + K)) ? wdata_i[LINES*H +: LINES] : '0;

    eint_group i_group (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg_q[g]),
      .lvl_i (lvl[LINES*g +: LINES]),
      .clr_i (clr),
      .pend_o(pend_flat[LINES*g +: LINES])
    );

    assign mask_flat[LINES*g +: LINES] = mask_q[g];
  end

  for (genvar g = 0; g < PAD_G; g++) begin : g_pad
    if (g < NUM_GROUPS) begin : g_real
      assign cfg_pad[g]  = cfg_q[g];
      assign mask_pad[g] = mask_q[g];
      assign pend_pad[g] = pend_flat[LINES*g +: LINES];
    end else begin : g_none
      assign cfg_pad[g]  = '0;
      assign mask_pad[g] = '0;
      assign pend_pad[g] = '0;
    end
  end

  eint_arbiter #(.NUM_GROUPS(NUM_GROUPS)) i_arb (
    .pend_i(pend_flat),
    .mask_i(mask_flat),
    .grp_o (svc_grp),
    .pin_o (svc_pin)
  );

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < MAX_REGS; k++) begin
      if (addr_i == ADDR_W'(CFG_BASE + k))  rd_word = {cfg_pad[2*k+1],  cfg_pad[2*k]};
      if (addr_i == ADDR_W'(MASK_BASE + k)) rd_word = {mask_pad[2*k+1], mask_pad[2*k]};
      if (addr_i == ADDR_W'(PEND_BASE + k)) rd_word = {pend_pad[2*k+1], pend_pad[2*k]};
    end
    if (addr_i == ADDR_W'(SVC_ADDR)) rd_word = {24'h0, svc_grp, svc_pin};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(pend_flat & ~mask_flat);

  AST_IRQ_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (svc_grp != 4'd0))
    else $error("irq and service word disagree"); // R9

  AST_SVC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_grp != 4'd0) |-> (int'(svc_grp) <= NUM_GROUPS &&
      pend_pad[svc_grp - 4'd1][svc_pin] && !mask_pad[svc_grp - 4'd1][svc_pin]))
    else $error("service names a line that is not pending and unmasked"); // R7

  AST_CFG_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(CFG_BASE + NUM_REGS)) |=> (rdata_o == 32'h0))
    else $error("config read beyond last pair not zero"); // R10
endmodule

// File: tb/test_grp_eint_ctrl.sv
module test_grp_eint_ctrl;
  localparam int G = 9;
  localparam int N = G * 16;
  localparam int NV = 16;
  // {code, before, after, expected pending}
  localparam logic [6:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b1, 1'b0}, {4'd0, 1'b1, 1'b0, 1'b1},
    {4'd1, 1'b0, 1'b0, 1'b0}, {4'd1, 1'b0, 1'b1, 1'b1},
    {4'd2, 1'b1, 1'b0, 1'b1}, {4'd2, 1'b0, 1'b1, 1'b0},
    {4'd2, 1'b1, 1'b1, 1'b0}, {4'd4, 1'b0, 1'b1, 1'b1},
    {4'd4, 1'b1, 1'b0, 1'b0}, {4'd6, 1'b0, 1'b1, 1'b1},
    {4'd6, 1'b1, 1'b0, 1'b1}, {4'd6, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 1'b0}, {4'd5, 1'b1, 1'b0, 1'b0},
    {4'd7, 1'b0, 1'b1, 1'b0}, {4'd15, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] gpio = '1;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  grp_eint_ctrl #(.NUM_GROUPS(G)) i_grp_eint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 rdata at reset", rdata, 32'h0);
    rst_n = 1'b1;
    idle(2);
    rd(5'd0, d);  chk("R1 cfg0 reset", d, 32'h0);
    rd(5'd8, d);  chk("R1 mask0 reset", d, 32'hFFFF_FFFF);
    rd(5'd16, d); chk("R1 pend0 reset", d, 32'h0);
    rd(5'd24, d); chk("R1 service reset", d, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    rd(5'd12, d); chk("R11 mask4 high half absent", d, 32'h0000_FFFF);

    // trigger table on group 0 line 0, lines 1-3 idle high
    for (int v = 0; v < NV; v++) begin
      wr(5'd0, 32'h3333_3333);
      gpio[0] = VEC[v][2];
      idle(4);
      wr(5'd16, 32'hFFFF_FFFF);
      wr(5'd0, {28'h333_3333, VEC[v][6:3]});
      gpio[0] = VEC[v][1];
      idle(4);
      rd(5'd16, d);
      chk($sformatf("R2 code %0d %b->%b", VEC[v][6:3], VEC[v][2], VEC[v][1]),
          {31'h0, d[0]}, {31'h0, VEC[v][0]});
    end
    gpio[0] = 1'b1;
    wr(5'd0, 32'h3333_3333);
    idle(4);
    wr(5'd16, 32'hFFFF_FFFF);

    // shared field: group 1 lines 4-7 rising, others unused
    wr(5'd0, 32'h3343_3333);
    gpio[22] = 1'b0; gpio[18] = 1'b0; gpio[6] = 1'b0;
    idle(4);
    gpio[22] = 1'b1; gpio[18] = 1'b1; gpio[6] = 1'b1;
    idle(4);
    rd(5'd16, d); chk("R3 only group1 pin6 pends", d, 32'h0040_0000);
    chk("R4 masked line no irq", {31'h0, irq}, 32'h0);
    rd(5'd24, d); chk("R4 masked line not serviced", d, 32'h0);

    wr(5'd8, 32'hFFBF_FFFF);
    chk("R9 unmasked pending drives irq", {31'h0, irq}, 32'h1);
    rd(5'd24, d); chk("R7 service group2 pin6", d, 32'h26);

    wr(5'd16, 32'h0);
    rd(5'd16, d); chk("R5 zero write keeps pending", d, 32'h0040_0000);

    // group 8 lines 0-3 level high, inputs high
    wr(5'd4, 32'h0000_0001);
    wr(5'd12, 32'h0000_FFF3);
    idle(2);
    rd(5'd24, d); chk("R7 lowest group wins", d, 32'h26);
    wr(5'd16, 32'h0040_0000);
    rd(5'd16, d); chk("R5 one write clears bit", d, 32'h0);
    rd(5'd24, d); chk("R7 lowest pin wins", d, 32'h92);
    wr(5'd20, 32'h0000_000F);
    rd(5'd20, d); chk("R6 level re-arms after clear", d & 32'hF, 32'hF);

    // latency on group 1 pin 6
    wr(5'd12, 32'h0000_FFFF);
    chk("R9 all masked irq low", {31'h0, irq}, 32'h0);
    gpio[22] = 1'b0;
    idle(4);
    gpio[22] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 irq low after two edges", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq high after three edges", {31'h0, irq}, 32'h1);

    wr(5'd24, 32'hFFFF_FFFF);
    rd(5'd24, d); chk("R10 service write ignored", d, 32'h26);
    rd(5'd30, d); chk("R10 unmapped reads zero", d, 32'h0);
    rd(5'd5, d);  chk("R10 cfg beyond pairs zero", d, 32'h0);
    wr(5'd4, 32'hFFFF_FFFF);
    rd(5'd4, d);  chk("R11 cfg4 high half absent", d, 32'h0000_FFFF);
    rd(5'd20, d); chk("R11 pend4 high half absent", d & 32'hFFFF_0000, 32'h0);
    d = rdata;
    idle(3);
    chk("R12 rdata holds between reads", rdata, d);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule